// File: doc/BRIEF.md
# Write-Masked Pin Function and Bias Register File

This block holds the function-select and bias setting of every pin across several 32-pin banks. Each pin has a 2-bit function field and a 2-bit bias field. All of them are driven continuously onto flat output vectors, which feed the pad ring. Software reaches the fields through a simple 32-bit register port. In each write word, the upper 16 bits act as per-bit write enables for the lower 16 bits. A driver can therefore change one pin's field in a single write, with no read-modify-write and no lock around the access.

The function registers and the bias registers sit in two separate address windows. Each bank occupies four words, and each word covers eight pins. Function fields are packed upward from bit 0. Bias fields are packed the other way round: the first pin of a word sits in the top field. Some pins of bank 0 have fixed behaviour. The first sixteen are permanently plain I/O and have no function storage. The first twelve take their bias from elsewhere, so this block holds no bias field for them.

Top module: `pincfg_regs`

## Requirements
- R1: On a write to a mapped word, stored bit n takes wdata bit n only when wdata bit n+16 is 1. Every other stored bit keeps its value. A write whose upper 16 bits are all zero changes nothing.
- R2: The function word for bank b, pin p is at byte address MUX_BASE + b*16 + (p/8)*4. Its 2-bit field occupies bits (p%8)*2+1:(p%8)*2 and appears on pin_mux[(b*32+p)*2 +: 2]. The value 0 means plain I/O.
- R3: The bias word for bank b, pin p is at byte address PULL_BASE + b*16 + (p/8)*4. Its field occupies bits (7-p%8)*2+1:(7-p%8)*2, which places the lowest pin at bits 15:14. The field appears on pin_pull[(b*32+p)*2 +: 2] with the codes 0 = off, 1 = up, 2 = down, 3 = hold.
- R4: Pins 0 to 15 of bank 0 always present function 0. The two function words covering them read as zero, and writes to those words have no effect.
- R5: Pins 0 to 11 of bank 0 always present bias 0. Their bias bits read as zero and ignore writes. Pins 12 to 15 of the same word (bits 7:0) store normally.
- R6: A read issued with rd_en returns its data one cycle later, with rd_valid high. Bits 31:16 are zero and bits 15:0 hold the stored word. A read and a write issued in the same cycle return the value from before the write.
- R7: Reset (synchronous, active high) clears every field, so all pins present plain I/O with bias off.
- R8: The following addresses read as zero and ignore writes: addresses that are not word-aligned, addresses outside both windows, and addresses between the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rdata | output | 32 | Read data, upper half zero |
| pin_mux | output | 256 | 2-bit function per pin, pin index b*32+p |
| pin_pull | output | 256 | 2-bit bias per pin, pin index b*32+p |

## Verification
The hardest case to reach is the bias word that bank 0 shares between stored and unstored pins. One write must leave bits 15:8 at zero while bits 7:0 take new values. The bench therefore writes all ones with every enable set, then checks both the read-back and the pin outputs for pins 8 to 15. It also issues partial-enable writes that touch single bits inside a field, and writes that carry data but no enables. A read and a write to the same word in the same cycle shows whether read data is taken before the update.

// File: rtl/pincfg_pkg.sv
`timescale 1ns/1ps
package pincfg_pkg;

    localparam int HALF_W          = 16;
    localparam int BUS_W           = 32;
    localparam int FIELD_W         = 2;
    localparam int FIELDS_PER_WORD = HALF_W / FIELD_W;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_MUX  = 2'd1,
        REGION_PULL = 2'd2
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] bank;
        logic [7:0] word;
    } target_t;

    // Bit position of field f inside a word; bias fields run high-to-low.
    function automatic int field_lsb(input bit is_pull, input int f);
        return is_pull ? (FIELDS_PER_WORD - 1 - f) * FIELD_W : f * FIELD_W;
    endfunction

    // Which stored bits exist for a given word (unbacked bits stay zero).
    function automatic logic [HALF_W-1:0] impl_bits(input bit is_pull, input int bank,
                                                    input int word, input int fixed_mux,
                                                    input int pull_away);
        logic [HALF_W-1:0] m;
        int pin;
        m = '0;
        for (int f = 0; f < FIELDS_PER_WORD; f++) begin
            pin = word * FIELDS_PER_WORD + f;
            if (is_pull) begin
                if (!(bank == 0 && pin < pull_away))
                    m[field_lsb(1'b1, f) +: FIELD_W] = '1;
            end else begin
                if (!(bank == 0 && pin < fixed_mux))
                    m[field_lsb(1'b0, f) +: FIELD_W] = '1;
            end
        end
        return m;
    endfunction

    // Upper half of the bus word enables bits of the lower half.
    function automatic logic [HALF_W-1:0] masked_merge(input logic [HALF_W-1:0] old,
                                                       input logic [BUS_W-1:0]  wr,
                                                       input logic [HALF_W-1:0] impl);
        logic [HALF_W-1:0] en;
        en = wr[BUS_W-1:HALF_W] & impl;
        return (old & ~en) | (wr[HALF_W-1:0] & en);
    endfunction

endpackage

// File: rtl/pincfg_decode.sv
`timescale 1ns/1ps
module pincfg_decode #(
    parameter int ADDR_W         = 12,
    parameter int NUM_BANKS      = 4,
    parameter int WORDS_PER_BANK = 4,
    parameter int MUX_BASE       = 'h0A8,
    parameter int PULL_BASE      = 'h164
) (
    input  logic [ADDR_W-1:0]   addr,
    output pincfg_pkg::target_t tgt
);
    import pincfg_pkg::*;

    localparam int BANK_STRIDE = WORDS_PER_BANK * 4;
    localparam int SPAN        = NUM_BANKS * BANK_STRIDE;

    int off_m;
    int off_p;

    always_comb begin
        off_m = int'(addr) - MUX_BASE;
        off_p = int'(addr) - PULL_BASE;
        tgt   = '{region: REGION_NONE, bank: 8'd0, word: 8'd0};
        if (addr[1:0] == 2'b00) begin
            if (off_m >= 0 && off_m < SPAN) begin
                tgt.region = REGION_MUX;
                tgt.bank   = 8'(off_m / BANK_STRIDE);
                tgt.word   = 8'((off_m % BANK_STRIDE) / 4);
            end else if (off_p >= 0 && off_p < SPAN) begin
                tgt.region = REGION_PULL;
                tgt.bank   = 8'(off_p / BANK_STRIDE);
                tgt.word   = 8'((off_p % BANK_STRIDE) / 4);
            end
        end
    end

endmodule

// File: rtl/pincfg_word.sv
`timescale 1ns/1ps
module pincfg_word #(
    parameter logic [15:0] IMPL = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [15:0] q
);
    import pincfg_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= masked_merge(q, wdata, IMPL);
    end

endmodule

// File: rtl/pincfg_regs.sv
`timescale 1ns/1ps
module pincfg_regs #(
    parameter int NUM_BANKS      = 4,
    parameter int PINS_PER_BANK  = 32,
    parameter int ADDR_W         = 12,
    parameter int MUX_BASE       = 'h0A8,
    parameter int PULL_BASE      = 'h164,
    parameter int FIXED_MUX_PINS = 16,
    parameter int PULL_AWAY_PINS = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic                          rd_valid,
    output logic [31:0]                   rdata,
    output logic [NUM_BANKS*PINS_PER_BANK*2-1:0] pin_mux,
    output logic [NUM_BANKS*PINS_PER_BANK*2-1:0] pin_pull
);
    import pincfg_pkg::*;

    localparam int WORDS_PER_BANK = PINS_PER_BANK / FIELDS_PER_WORD;
    localparam int NUM_PINS       = NUM_BANKS * PINS_PER_BANK;

    target_t     tgt;
    logic [15:0] mux_q  [NUM_BANKS][WORDS_PER_BANK];
    logic [15:0] pull_q [NUM_BANKS][WORDS_PER_BANK];
    logic [15:0] rd_word;

    pincfg_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .WORDS_PER_BANK(WORDS_PER_BANK),
        .MUX_BASE(MUX_BASE), .PULL_BASE(PULL_BASE)
    ) u_decode (
        .addr (addr),
        .tgt  (tgt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar w = 0; w < WORDS_PER_BANK; w++) begin : g_word
            logic hit;
            assign hit = wr_en && tgt.bank == 8'(b) && tgt.word == 8'(w);

            pincfg_word #(
                .IMPL(impl_bits(1'b0, b, w, FIXED_MUX_PINS, PULL_AWAY_PINS))
            ) u_mux (
                .clk(clk), .rst(rst), .we(hit && tgt.region == REGION_MUX),
                .wdata(wdata), .q(mux_q[b][w])
            );

            pincfg_word #(
                .IMPL(impl_bits(1'b1, b, w, FIXED_MUX_PINS, PULL_AWAY_PINS))
            ) u_pull (
                .clk(clk), .rst(rst), .we(hit && tgt.region == REGION_PULL),
                .wdata(wdata), .q(pull_q[b][w])
            );
        end

        for (genvar p = 0; p < PINS_PER_BANK; p++) begin : g_pin
            localparam int W  = p / FIELDS_PER_WORD;
            localparam int ML = field_lsb(1'b0, p % FIELDS_PER_WORD);
            localparam int PL = field_lsb(1'b1, p % FIELDS_PER_WORD);
            assign pin_mux [(b*PINS_PER_BANK+p)*FIELD_W +: FIELD_W] = mux_q[b][W][ML +: FIELD_W];
            assign pin_pull[(b*PINS_PER_BANK+p)*FIELD_W +: FIELD_W] = pull_q[b][W][PL +: FIELD_W];
        end
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int w = 0; w < WORDS_PER_BANK; w++) begin
                if (tgt.bank == 8'(b) && tgt.word == 8'(w)) begin
                    if (tgt.region == REGION_MUX)  rd_word = mux_q[b][w];
                    if (tgt.region == REGION_PULL) rd_word = pull_q[b][w];
                end
            end
        end
    end

    // Read data is captured before any same-cycle write lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rdata <= {16'h0000, rd_word};
        end
    end

endmodule

// File: rtl/pincfg_checks.sv
`timescale 1ns/1ps
module pincfg_checks #(
    parameter int NUM_PINS       = 128,
    parameter int FIXED_MUX_PINS = 16,
    parameter int PULL_AWAY_PINS = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [31:0]           wdata,
    input logic                  rd_valid,
    input logic [31:0]           rdata,
    input logic [NUM_PINS*2-1:0] pin_mux,
    input logic [NUM_PINS*2-1:0] pin_pull
);
    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pin_mux == '0 && pin_pull == '0 && !rd_valid));

    // R6
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R6
    read_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rdata[31:16] == 16'h0000);

    // R4
    fixed_mux_chk: assert property (@(posedge clk) disable iff (rst)
        pin_mux[FIXED_MUX_PINS*2-1:0] == '0);

    // R5
    pull_away_chk: assert property (@(posedge clk) disable iff (rst)
        pin_pull[PULL_AWAY_PINS*2-1:0] == '0);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pin_mux) && $stable(pin_pull)));

    // R1
    no_enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[31:16] == 16'h0000) |=> ($stable(pin_mux) && $stable(pin_pull)));
endmodule

bind pincfg_regs pincfg_checks #(
    .NUM_PINS(NUM_PINS), .FIXED_MUX_PINS(FIXED_MUX_PINS), .PULL_AWAY_PINS(PULL_AWAY_PINS)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rd_valid(rd_valid), .rdata(rdata), .pin_mux(pin_mux), .pin_pull(pin_pull)
);

// File: tb/test_pincfg_regs.sv
`timescale 1ns/1ps
module test_pincfg_regs;
    localparam int NB = 4;
    localparam int NP = 32;
    localparam logic [11:0] MB = 12'h0A8;
    localparam logic [11:0] PB = 12'h164;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic rd_valid;
    logic [31:0] rdata;
    logic [NB*NP*2-1:0] pin_mux, pin_pull;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [1:0] m_mux  [NB][NP];
    logic [1:0] m_pull [NB][NP];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    pincfg_regs i_pincfg_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rd_valid(rd_valid), .rdata(rdata), .pin_mux(pin_mux), .pin_pull(pin_pull)
    );

    task automatic model_clear();
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++) begin
                m_mux[b][p]  = 2'd0;
                m_pull[b][p] = 2'd0;
            end
    endtask

    // Returns region (0 none, 1 function, 2 bias), bank, word per R2/R3/R8.
    function automatic int locate(input logic [11:0] a, output int b, output int w);
        int om, op;
        om = int'(a) - int'(MB);
        op = int'(a) - int'(PB);
        b = 0; w = 0;
        if (a[1:0] != 2'b00) return 0;
        if (om >= 0 && om < NB*16) begin b = om / 16; w = (om % 16) / 4; return 1; end
        if (op >= 0 && op < NB*16) begin b = op / 16; w = (op % 16) / 4; return 2; end
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int b, w, r, pin;
        logic [31:0] v;
        v = '0;
        r = locate(a, b, w);
        for (int f = 0; f < 8; f++) begin
            pin = w*8 + f;
            if (r == 1) v[f*2 +: 2] = m_mux[b][pin];
            if (r == 2) v[(7-f)*2 +: 2] = m_pull[b][pin];
        end
        return v;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int b, w, r, pin, pos;
        r = locate(a, b, w);
        for (int f = 0; f < 8; f++) begin
            pin = w*8 + f;
            if (r == 1 && !(b == 0 && pin < 16)) begin
                pos = f*2;
                for (int k = 0; k < 2; k++)
                    if (d[16+pos+k]) m_mux[b][pin][k] = d[pos+k];
            end
            if (r == 2 && !(b == 0 && pin < 12)) begin
                pos = (7-f)*2;
                for (int k = 0; k < 2; k++)
                    if (d[16+pos+k]) m_pull[b][pin][k] = d[pos+k];
            end
        end
    endtask

    // Driver: pushes the expected read item, then updates the model.
    task automatic bus(input bit w, input bit r, input logic [11:0] a,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        if (r) begin
            exp_q.push_back(model_read(a));
            tag_q.push_back(tag);
        end
        if (w) model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic chk_pins(input string tag);
        logic [NB*NP*2-1:0] em, ep;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++) begin
                em[(b*NP+p)*2 +: 2] = m_mux[b][p];
                ep[(b*NP+p)*2 +: 2] = m_pull[b][p];
            end
        checks++;
        if (pin_mux !== em || pin_pull !== ep) begin
            errors++;
            $display("FAIL %s pins: mux %h pull %h expected mux %h pull %h",
                     tag, pin_mux, pin_pull, em, ep);
        end
    endtask

    // Monitor: pops expected reads as results appear.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected read data %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s read: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        chk_pins("R7");
        bus(0, 1, MB + 12'h020, 32'h0, "R7");

        // R2 full write to bank1 word2 (pins 16..23), then a bank3 last word
        bus(1, 0, MB + 12'h018, 32'hFFFF_E4B1, "R2");
        chk_pins("R2");
        bus(0, 1, MB + 12'h018, 32'h0, "R2");
        bus(1, 1, MB + 12'h03C, 32'hFFFF_C003, "R2");
        chk_pins("R2");

        // R1 partial enables: clear one field, flip one single bit, no-enable write
        bus(1, 0, MB + 12'h018, 32'h000C_0000, "R1");
        bus(1, 0, MB + 12'h018, 32'h4000_4000, "R1");
        bus(1, 0, MB + 12'h018, 32'h0000_FFFF, "R1");
        chk_pins("R1");
        bus(0, 1, MB + 12'h018, 32'h0, "R1");

        // R3 reversed bias order and all four codes, bank2 word1 and bank3 word3
        bus(1, 0, PB + 12'h024, 32'hFFFF_1BE4, "R3");
        bus(1, 0, PB + 12'h03C, 32'hC000_C000, "R3");
        chk_pins("R3");
        bus(0, 1, PB + 12'h024, 32'h0, "R3");
        bus(0, 1, PB + 12'h03C, 32'h0, "R3");

        // R4 fixed function pins of bank 0
        bus(1, 0, MB + 12'h000, 32'hFFFF_FFFF, "R4");
        bus(1, 0, MB + 12'h004, 32'hFFFF_AAAA, "R4");
        bus(1, 0, MB + 12'h008, 32'hFFFF_5555, "R4");
        chk_pins("R4");
        bus(0, 1, MB + 12'h000, 32'h0, "R4");
        bus(0, 1, MB + 12'h004, 32'h0, "R4");
        bus(0, 1, MB + 12'h008, 32'h0, "R4");

        // R5 bias word shared by unstored and stored pins of bank 0
        bus(1, 0, PB + 12'h000, 32'hFFFF_FFFF, "R5");
        bus(1, 0, PB + 12'h004, 32'hFFFF_FFFF, "R5");
        chk_pins("R5");
        bus(0, 1, PB + 12'h000, 32'h0, "R5");
        bus(0, 1, PB + 12'h004, 32'h0, "R5");

        // R8 misaligned, below, above and between windows
        bus(1, 1, MB - 12'h004, 32'hFFFF_FFFF, "R8");
        bus(1, 1, MB + 12'h019, 32'hFFFF_0000, "R8");
        bus(1, 1, MB + 12'h040, 32'hFFFF_FFFF, "R8");
        bus(1, 1, PB + 12'h040, 32'hFFFF_FFFF, "R8");
        bus(1, 1, 12'h100,      32'hFFFF_FFFF, "R8");
        chk_pins("R8");

        // R6 same-cycle read and write returns old data, then new data
        bus(1, 1, MB + 12'h018, 32'hFFFF_0F0F, "R6");
        bus(0, 1, MB + 12'h018, 32'h0, "R6");
        bus(1, 1, PB + 12'h024, 32'hFFFF_0000, "R6");
        bus(0, 1, PB + 12'h024, 32'h0, "R6");
        chk_pins("R6");

        // R7 reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        model_clear();
        chk_pins("R7");
        bus(0, 1, PB + 12'h03C, 32'h0, "R7");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 missing reads: %0d outstanding expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule